// File: doc/BRIEF.md
# Cache Timing Model

This block predicts how long a memory access would take in a simulated target cache. It never touches the data. A functional model hands it one request per host cycle: a context ID, a byte address and a read/write flag. One cycle later the block answers with a hit flag and the number of target cycles the requester must stall.

Inside, it keeps only tags, valid bits, dirty bits and LRU ages. The target cache can therefore be far larger in data than the host storage the model uses. Set count, active associativity, miss penalty and dirty-writeback penalty are registers written at run time, so one build covers several target configurations. For example, with the default maximums it covers:

- 64 sets direct-mapped;
- 16 sets with 4 ways, which is the same capacity;
- 128 sets direct-mapped, which is double the capacity.

Saturating hit, miss and writeback counters record the activity. A dedicated input clears them.

A small control machine has two states:

- **FLUSH** clears every valid and dirty bit and restores the LRU ages. Requests are refused in this state.
- **READY** accepts requests.

It has four transitions:

- *reset → FLUSH*
- *FLUSH → READY*: always, after one cycle.
- *READY → FLUSH*: when a configuration write is taken.
- *READY → READY*: otherwise.

Top module: `cache_timing_model`

## Requirements
- R1: After reset is released, `req_ready` is low for exactly one cycle and then high. `resp_valid` is low and all counters read zero. The first access to any line misses.
- R2: Two requests match the same line only when both the context ID and the address bits above the low `OFF_W` offset bits are equal. The offset bits never affect the result, and a different context ID never hits on another context's line.
- R3: A hit reports a stall of 0. A miss whose victim way is invalid or clean reports a stall equal to the configured miss penalty.
- R4: Every accepted request (`req_valid` and `req_ready` both high at a clock edge) produces `resp_valid` high for exactly the following cycle, and no other cycle has `resp_valid` high. A new request may be accepted every cycle, and a request sees every update made by the request accepted one cycle earlier.
- R5: The set index is the low `cfg_set_bits` bits of the line address, which is `req_addr[ADDR_W-1:OFF_W]`. Two lines whose line addresses agree in those bits compete for the same set.
- R6: The active way count is 2 raised to `cfg_way_log2`, limited to `MAX_WAYS` (a value of 3 acts as 4 ways when `MAX_WAYS` is 4). On a miss, the lowest-numbered invalid active way is filled first. If all active ways are valid, the least recently accessed active way is replaced. Inactive ways are never filled.
- R7: A write that hits marks the line dirty. A write that misses allocates the line as dirty, and a read miss allocates it clean. A miss that evicts a valid dirty line reports the miss penalty plus the writeback penalty and increments the writeback counter.
- R8: A configuration write (`cfg_we` high) is taken only in READY. In that cycle and in the following FLUSH cycle `req_ready` is low and no request is accepted. Afterwards every previously held line misses, and the new set count, way count and penalties are in force.
- R9: The hit and miss counters each increment once per accepted hit or miss, and the writeback counter once per dirty eviction. Each stops at its all-ones value. `cnt_clear` zeroes all three on the next edge and takes priority over an increment in the same cycle.
- R10: After reset the model is direct-mapped with 2^`MAX_IDX_W` sets, a miss penalty of `DEF_MISS_PEN` and a writeback penalty of `DEF_WB_PEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_set_bits | input | $clog2(MAX_IDX_W+1) | Number of index bits (sets = 2^value) |
| cfg_way_log2 | input | $clog2($clog2(MAX_WAYS)+1) | Log2 of active way count |
| cfg_miss_pen | input | PEN_W | Stall cycles charged for a miss |
| cfg_wb_pen | input | PEN_W | Extra stall cycles for evicting a dirty line |
| cnt_clear | input | 1 | Clears all performance counters |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Model can accept a request this cycle |
| req_ctx | input | CTX_W | Context ID of the requester |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| resp_valid | output | 1 | Response for the request accepted last cycle |
| resp_hit | output | 1 | 1 when that request hit |
| resp_stall | output | PEN_W+1 | Target stall cycles for that request |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |
| wb_count | output | CNT_W | Saturating dirty-eviction counter |

## Verification
A corrupted tag, valid or dirty bit appears at the ports no later than the next request to the same set. It shows as a flipped `resp_hit` or as a stall off by exactly one penalty, so a replayed trace exposes it within a few accesses. Broken LRU ages stay hidden while invalid ways remain. They surface only once an active set is full: the first conflicting miss picks the wrong victim, and the error becomes visible when the evicted or retained line is accessed again. A FLUSH that leaves state behind shows as a hit on the first access after a configuration write.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    typedef enum logic [0:0] {
        ST_FLUSH = 1'b0,
        ST_READY = 1'b1
    } ctm_state_e;

endpackage

// File: rtl/ctm_tag_store.sv
module ctm_tag_store #(
    parameter int IDX_W = 7,
    parameter int WAYS  = 4,
    parameter int TAG_W = 33,
    parameter int WAY_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [IDX_W-1:0]            lk_set,
    input  logic [TAG_W-1:0]            lk_tag,
    output logic [WAYS-1:0]             lk_match,
    output logic [WAYS-1:0]             lk_valid,
    output logic [WAYS-1:0]             lk_dirty,
    output logic [WAYS-1:0][WAY_W-1:0]  lk_age,
    input  logic                        upd_en,
    input  logic [WAY_W-1:0]            upd_way,
    input  logic [TAG_W-1:0]            upd_tag,
    input  logic                        upd_dirty
);

    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0]           tag_q   [SETS][WAYS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0]            dirty_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0] age_q   [SETS];

    // Parallel tag compare across every way of the addressed set
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign lk_match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        end
    endgenerate

    assign lk_valid = valid_q[lk_set];
    assign lk_dirty = dirty_q[lk_set];
    assign lk_age   = age_q[lk_set];

    // Metadata: valid, dirty and LRU ages (ages are a permutation of 0..WAYS-1)
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (upd_en) begin
            valid_q[lk_set][upd_way] <= 1'b1;
            dirty_q[lk_set][upd_way] <= upd_dirty;
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way) begin
                    age_q[lk_set][w] <= '0;
                end else if (age_q[lk_set][w] < age_q[lk_set][upd_way]) begin
                    age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
                end
            end
        end
    end

    // Tags carry no reset: valid bits qualify them
    always_ff @(posedge clk) begin
        if (rst_n && !flush && upd_en) begin
            tag_q[lk_set][upd_way] <= upd_tag;
        end
    end

    // R2: a line is never resident twice in one set
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R8: a flush leaves the set seen next cycle empty
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (lk_valid == '0));

endmodule

// File: rtl/ctm_victim_sel.sv
module ctm_victim_sel #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][WAY_W-1:0]  age,
    input  logic [WAYS-1:0]             active,
    output logic [WAY_W-1:0]            victim
);

    logic             any_free;
    logic [WAY_W-1:0] best_age;

    always_comb begin
        any_free = 1'b0;
        best_age = '0;
        victim   = '0;
        // Lowest-numbered invalid active way first
        for (int w = 0; w < WAYS; w++) begin
            if (active[w] && !valid[w] && !any_free) begin
                victim   = WAY_W'(w);
                any_free = 1'b1;
            end
        end
        // Otherwise the oldest active way
        if (!any_free) begin
            for (int w = 0; w < WAYS; w++) begin
                if (active[w] && (age[w] >= best_age)) begin
                    best_age = age[w];
                    victim   = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/ctm_sat_counter.sv
module ctm_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '1) && !clear) |=> (count == '1));

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

endmodule

// File: rtl/cache_timing_model.sv
module cache_timing_model #(
    parameter int CTX_W        = 6,
    parameter int ADDR_W       = 32,
    parameter int OFF_W        = 5,
    parameter int MAX_IDX_W    = 7,
    parameter int MAX_WAYS     = 4,
    parameter int PEN_W        = 16,
    parameter int CNT_W        = 32,
    parameter int DEF_MISS_PEN = 8,
    parameter int DEF_WB_PEN   = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_we,
    input  logic [$clog2(MAX_IDX_W+1)-1:0]         cfg_set_bits,
    input  logic [$clog2($clog2(MAX_WAYS)+1)-1:0]  cfg_way_log2,
    input  logic [PEN_W-1:0]                       cfg_miss_pen,
    input  logic [PEN_W-1:0]                       cfg_wb_pen,
    input  logic                                   cnt_clear,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic [CTX_W-1:0]                       req_ctx,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic                                   req_write,
    output logic                                   resp_valid,
    output logic                                   resp_hit,
    output logic [PEN_W:0]                         resp_stall,
    output logic [CNT_W-1:0]                       hit_count,
    output logic [CNT_W-1:0]                       miss_count,
    output logic [CNT_W-1:0]                       wb_count
);
    import ctm_pkg::*;

    localparam int WAY_W = $clog2(MAX_WAYS);
    localparam int SB_W  = $clog2(MAX_IDX_W + 1);
    localparam int WL_W  = $clog2(WAY_W + 1);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int TAG_W = CTX_W + BLK_W;

    // ---------------- control state machine ----------------
    ctm_state_e state_q, state_d;
    logic       flush;
    logic       cfg_take;
    logic       fire;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLUSH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH: state_d = ST_READY;
            ST_READY: if (cfg_we) state_d = ST_FLUSH;
            default:  state_d = ST_FLUSH;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        flush     = 1'b0;
        cfg_take  = 1'b0;
        unique case (state_q)
            ST_FLUSH: flush = 1'b1;
            ST_READY: begin
                cfg_take  = cfg_we;
                req_ready = !cfg_we;
            end
            default:  flush = 1'b1;
        endcase
    end

    assign fire = req_valid && req_ready;

    // ---------------- configuration registers ----------------
    logic [SB_W-1:0]  set_bits_q;
    logic [WL_W-1:0]  way_log2_q;
    logic [PEN_W-1:0] miss_pen_q;
    logic [PEN_W-1:0] wb_pen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_bits_q <= SB_W'(MAX_IDX_W);
            way_log2_q <= '0;
            miss_pen_q <= PEN_W'(DEF_MISS_PEN);
            wb_pen_q   <= PEN_W'(DEF_WB_PEN);
        end else if (cfg_take) begin
            set_bits_q <= (int'(cfg_set_bits) > MAX_IDX_W) ? SB_W'(MAX_IDX_W) : cfg_set_bits;
            way_log2_q <= (int'(cfg_way_log2) > WAY_W) ? WL_W'(WAY_W) : cfg_way_log2;
            miss_pen_q <= cfg_miss_pen;
            wb_pen_q   <= cfg_wb_pen;
        end
    end

    // ---------------- address split and masks ----------------
    logic [BLK_W-1:0]     blk_addr;
    logic [MAX_IDX_W-1:0] set_mask;
    logic [MAX_IDX_W-1:0] set_idx;
    logic [MAX_WAYS-1:0]  way_active;
    logic [TAG_W-1:0]     lk_tag;
    logic                 unused_offset;

    assign blk_addr      = req_addr[ADDR_W-1:OFF_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];
    assign lk_tag        = {req_ctx, blk_addr};

    generate
        for (genvar i = 0; i < MAX_IDX_W; i++) begin : g_setmask
            assign set_mask[i] = (i < int'(set_bits_q));
        end
        for (genvar w = 0; w < MAX_WAYS; w++) begin : g_waymask
            assign way_active[w] = (w < (1 << int'(way_log2_q)));
        end
    endgenerate

    assign set_idx = blk_addr[MAX_IDX_W-1:0] & set_mask;

    // ---------------- tag store and replacement ----------------
    logic [MAX_WAYS-1:0]             raw_match, hit_vec, way_valid, way_dirty;
    logic [MAX_WAYS-1:0][WAY_W-1:0]  way_age;
    logic [WAY_W-1:0]                hit_way, victim, pick_way;
    logic                            hit, evict_dirty, new_dirty;

    ctm_tag_store #(
        .IDX_W (MAX_IDX_W),
        .WAYS  (MAX_WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_set   (set_idx),
        .lk_tag   (lk_tag),
        .lk_match (raw_match),
        .lk_valid (way_valid),
        .lk_dirty (way_dirty),
        .lk_age   (way_age),
        .upd_en   (fire),
        .upd_way  (pick_way),
        .upd_tag  (lk_tag),
        .upd_dirty(new_dirty)
    );

    ctm_victim_sel #(
        .WAYS  (MAX_WAYS),
        .WAY_W (WAY_W)
    ) u_victim (
        .valid  (way_valid),
        .age    (way_age),
        .active (way_active),
        .victim (victim)
    );

    assign hit_vec = raw_match & way_active;
    assign hit     = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < MAX_WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign pick_way    = hit ? hit_way : victim;
    assign evict_dirty = !hit && way_valid[victim] && way_dirty[victim];
    assign new_dirty   = req_write || (hit && way_dirty[hit_way]);

    // ---------------- response register ----------------
    logic [PEN_W:0] stall_d;

    assign stall_d = hit ? '0
                   : ({1'b0, miss_pen_q} + (evict_dirty ? {1'b0, wb_pen_q} : '0));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_stall <= '0;
        end else begin
            resp_valid <= fire;
            if (fire) begin
                resp_hit   <= hit;
                resp_stall <= stall_d;
            end
        end
    end

    // ---------------- performance counters ----------------
    ctm_sat_counter #(.W(CNT_W)) u_hits (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .inc(fire && hit), .count(hit_count)
    );
    ctm_sat_counter #(.W(CNT_W)) u_misses (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .inc(fire && !hit), .count(miss_count)
    );
    ctm_sat_counter #(.W(CNT_W)) u_wbs (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .inc(fire && evict_dirty), .count(wb_count)
    );

    // ---------------- assertions ----------------
    p_resp_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> resp_valid);

    p_no_spurious_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !resp_valid);

    p_hit_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> (resp_stall == '0));

    p_miss_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hit) |=> (resp_stall >= {1'b0, miss_pen_q}));

    p_victim_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hit) |-> way_active[victim]);

    p_cfg_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_take |=> (!req_ready && !resp_valid));

endmodule

// File: tb/cache_timing_model_test.sv
`timescale 1ns/1ps
module cache_timing_model_test;

    localparam int CTX_W = 6, ADDR_W = 32, OFF_W = 5, MAX_IDX_W = 7, MAX_WAYS = 4;
    localparam int PEN_W = 16, CNT_W = 8, DEF_MISS = 8, DEF_WB = 4;
    localparam int SETS = 1 << MAX_IDX_W;
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int TAG_W = CTX_W + BLK_W;
    localparam int CMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, cnt_clear = 1'b0;
    logic [2:0] cfg_set_bits = '0;
    logic [1:0] cfg_way_log2 = '0;
    logic [PEN_W-1:0] cfg_miss_pen = '0, cfg_wb_pen = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [CTX_W-1:0] req_ctx = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, resp_valid, resp_hit;
    logic [PEN_W:0] resp_stall;
    logic [CNT_W-1:0] hit_count, miss_count, wb_count;

    always #4 clk = ~clk;

    cache_timing_model #(
        .CTX_W(CTX_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MAX_IDX_W(MAX_IDX_W),
        .MAX_WAYS(MAX_WAYS), .PEN_W(PEN_W), .CNT_W(CNT_W),
        .DEF_MISS_PEN(DEF_MISS), .DEF_WB_PEN(DEF_WB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_set_bits(cfg_set_bits),
        .cfg_way_log2(cfg_way_log2), .cfg_miss_pen(cfg_miss_pen), .cfg_wb_pen(cfg_wb_pen),
        .cnt_clear(cnt_clear), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctx(req_ctx), .req_addr(req_addr), .req_write(req_write),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_stall(resp_stall),
        .hit_count(hit_count), .miss_count(miss_count), .wb_count(wb_count)
    );

    int checks = 0, errors = 0;

    // ---------------- reference model ----------------
    int m_set_bits = MAX_IDX_W, m_ways = 1, m_miss = DEF_MISS, m_wb = DEF_WB;
    bit m_valid [SETS][MAX_WAYS];
    bit m_dirty [SETS][MAX_WAYS];
    logic [TAG_W-1:0] m_tag [SETS][MAX_WAYS];
    int m_stamp [SETS][MAX_WAYS];
    int now_t = 0;
    int e_hits = 0, e_miss = 0, e_wbs = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < MAX_WAYS; w++) begin
                m_valid[s][w] = 1'b0;
                m_dirty[s][w] = 1'b0;
                m_stamp[s][w] = 0;
            end
    endtask

    task automatic model_step(input logic [CTX_W-1:0] ctx, input logic [ADDR_W-1:0] addr,
                              input bit wr, output bit hit, output int stall);
        logic [BLK_W-1:0] blk;
        logic [TAG_W-1:0] tg;
        int set, way, oldest;
        bit found, wbk;
        blk = addr[ADDR_W-1:OFF_W];
        set = int'(blk) & ((1 << m_set_bits) - 1);
        tg  = {ctx, blk};
        hit = 1'b0; way = 0; wbk = 1'b0;
        for (int w = 0; w < m_ways; w++)
            if (m_valid[set][w] && m_tag[set][w] == tg) begin hit = 1'b1; way = w; end
        if (!hit) begin
            found = 1'b0;
            for (int w = 0; w < m_ways; w++)
                if (!m_valid[set][w] && !found) begin way = w; found = 1'b1; end
            if (!found) begin
                oldest = m_stamp[set][0]; way = 0;
                for (int w = 1; w < m_ways; w++)
                    if (m_stamp[set][w] < oldest) begin oldest = m_stamp[set][w]; way = w; end
            end
            wbk = m_valid[set][way] && m_dirty[set][way];
        end
        stall = hit ? 0 : (m_miss + (wbk ? m_wb : 0));
        m_dirty[set][way] = hit ? (m_dirty[set][way] | wr) : wr;
        m_valid[set][way] = 1'b1;
        m_tag[set][way]   = tg;
        now_t++;
        m_stamp[set][way] = now_t;
        if (hit) begin if (e_hits < CMAX) e_hits++; end
        else     begin if (e_miss < CMAX) e_miss++; end
        if (wbk && e_wbs < CMAX) e_wbs++;
    endtask

    // ---------------- driver tasks ----------------
    task automatic access(input logic [CTX_W-1:0] ctx, input logic [ADDR_W-1:0] addr,
                          input bit wr, input string req);
        bit eh;
        int es;
        #1;
        check(req_ready === 1'b1, "R4", "req_ready before request", req_ready, 1);
        req_valid = 1'b1; req_ctx = ctx; req_addr = addr; req_write = wr;
        model_step(ctx, addr, wr, eh, es);
        @(negedge clk);
        check(resp_valid === 1'b1, "R4", "resp_valid after accept", resp_valid, 1);
        check(resp_hit === eh, req, "resp_hit", resp_hit, eh);
        check(resp_stall === (PEN_W+1)'(es), req, "resp_stall", resp_stall, es);
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        @(negedge clk);
        check(resp_valid === 1'b0, "R4", "resp_valid with no request", resp_valid, 0);
    endtask

    task automatic check_counters(input string req);
        check(hit_count === CNT_W'(e_hits), req, "hit_count", hit_count, e_hits);
        check(miss_count === CNT_W'(e_miss), req, "miss_count", miss_count, e_miss);
        check(wb_count === CNT_W'(e_wbs), req, "wb_count", wb_count, e_wbs);
    endtask

    task automatic configure(input int sb, input int wl, input int mp, input int wp);
        cfg_we = 1'b1; cfg_set_bits = 3'(sb); cfg_way_log2 = 2'(wl);
        cfg_miss_pen = PEN_W'(mp); cfg_wb_pen = PEN_W'(wp);
        req_valid = 1'b1;
        #1;
        check(req_ready === 1'b0, "R8", "req_ready in config cycle", req_ready, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(req_ready === 1'b0, "R8", "req_ready in flush cycle", req_ready, 0);
        check(resp_valid === 1'b0, "R8", "resp during config", resp_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready === 1'b1, "R8", "req_ready after flush", req_ready, 1);
        check(resp_valid === 1'b0, "R8", "resp during flush", resp_valid, 0);
        m_set_bits = (sb > MAX_IDX_W) ? MAX_IDX_W : sb;
        m_ways = 1 << ((wl > 2) ? 2 : wl);
        m_miss = mp; m_wb = wp;
        model_flush();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(req_ready === 1'b0, "R1", "req_ready first cycle", req_ready, 0);
        check(resp_valid === 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
        check_counters("R1");
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "req_ready second cycle", req_ready, 1);
        model_flush();
    endtask

    task automatic t_defaults_and_match();
        access(6'd0, 32'h0000_1000, 1'b0, "R1");   // cold miss, default penalty (R10)
        access(6'd0, 32'h0000_101C, 1'b0, "R2");   // same line, other offset: hit
        access(6'd1, 32'h0000_1000, 1'b0, "R2");   // other context: miss
        access(6'd0, 32'h0000_1000 + 32'(SETS*32), 1'b0, "R10"); // 128-set alias conflict
        access(6'd0, 32'h0000_1000 + 32'(64*32), 1'b0, "R10");   // not an alias at 128 sets
        go_idle();
        check_counters("R9");
    endtask

    task automatic t_dirty();
        access(6'd2, 32'h0000_0040, 1'b1, "R7");   // write miss allocates dirty
        access(6'd2, 32'h0000_0044, 1'b1, "R7");   // write hit
        access(6'd2, 32'h0000_0040 + 32'(SETS*32), 1'b0, "R7"); // evicts dirty: miss+wb
        access(6'd2, 32'h0000_0040, 1'b0, "R7");   // victim was clean read line
        access(6'd3, 32'h0000_0080, 1'b0, "R7");   // read miss clean
        access(6'd3, 32'h0000_0080, 1'b1, "R7");   // write hit marks dirty
        access(6'd3, 32'h0000_0080 + 32'(SETS*32), 1'b0, "R7");
        go_idle();
        check_counters("R7");
    endtask

    task automatic t_index();
        configure(2, 0, 11, 5);                   // 4 sets direct-mapped
        access(6'd0, 32'h0000_0000, 1'b0, "R5");
        access(6'd0, 32'h0000_0080, 1'b0, "R5");  // line 4 -> set 0, evicts
        access(6'd0, 32'h0000_0000, 1'b0, "R5");  // misses again
        access(6'd0, 32'h0000_0020, 1'b0, "R5");  // set 1
        access(6'd0, 32'h0000_0000, 1'b0, "R5");  // still resident
        go_idle();
    endtask

    task automatic t_lru();
        logic [ADDR_W-1:0] base;
        configure(4, 2, 13, 6);                   // 16 sets x 4 ways
        base = 32'h0000_0060;
        for (int k = 0; k < 4; k++) access(6'd0, base + 32'(k*16*32), 1'b0, "R6");
        access(6'd0, base, 1'b0, "R6");           // touch line 0
        access(6'd0, base + 32'(4*16*32), 1'b0, "R6"); // evicts line 1
        access(6'd0, base + 32'(1*16*32), 1'b0, "R6"); // line 1 misses
        access(6'd0, base, 1'b0, "R6");           // line 0 kept
        access(6'd0, base + 32'(2*16*32), 1'b0, "R6");
        go_idle();
        configure(4, 3, 9, 2);                    // value 3 acts as 4 ways
        for (int k = 0; k < 4; k++) access(6'd1, 32'(k*16*32), 1'b0, "R6");
        for (int k = 0; k < 4; k++) access(6'd1, 32'(k*16*32), 1'b0, "R6");
        go_idle();
        configure(4, 1, 9, 2);                    // 2 ways
        for (int k = 0; k < 3; k++) access(6'd1, 32'(k*16*32), 1'b0, "R6");
        access(6'd1, 32'h0, 1'b0, "R6");          // evicted by third line
        go_idle();
    endtask

    task automatic t_back_to_back();
        access(6'd5, 32'h0000_0400, 1'b1, "R4");
        access(6'd5, 32'h0000_0404, 1'b0, "R4");  // next cycle sees the fill
        access(6'd5, 32'h0000_0400 + 32'(2*16*32), 1'b0, "R4");
        access(6'd5, 32'h0000_0400, 1'b0, "R4");
        go_idle();
    endtask

    task automatic t_trace(input int sb, input int wl, input int mp, input int wp,
                           input logic [31:0] seed0);
        logic [31:0] s;
        int blk;
        configure(sb, wl, mp, wp);
        s = seed0;
        for (int i = 0; i < 250; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            blk = int'(s[23:8]) % 192;
            access(CTX_W'(s[20]), 32'(blk << OFF_W) | 32'(s[4:0]), s[27], "R3");
        end
        go_idle();
        check_counters("R9");
    endtask

    task automatic t_reconfig_flush();
        access(6'd7, 32'h0000_2000, 1'b0, "R8");
        access(6'd7, 32'h0000_2000, 1'b0, "R8");
        go_idle();
        configure(6, 0, 15, 3);
        access(6'd7, 32'h0000_2000, 1'b0, "R8");  // flushed: miss at new penalty
        go_idle();
    endtask

    task automatic t_counters();
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
        e_hits = 0; e_miss = 0; e_wbs = 0;
        check_counters("R9");
        cnt_clear = 1'b1;                          // clear wins over increment
        access(6'd9, 32'h0000_3000, 1'b1, "R9");
        cnt_clear = 1'b0;
        e_hits = 0; e_miss = 0; e_wbs = 0;
        check_counters("R9");
        for (int i = 0; i < 300; i++) access(6'd9, 32'h0000_3000, 1'b0, "R9");
        go_idle();
        check(hit_count === CNT_W'(CMAX), "R9", "hit_count saturated", hit_count, CMAX);
        check_counters("R9");
    endtask

    initial begin
        t_reset();
        t_defaults_and_match();
        t_dirty();
        t_index();
        t_lru();
        t_back_to_back();
        t_trace(6, 0, 10, 6, 32'h1234_5678);      // 64 sets direct-mapped
        t_trace(4, 2, 10, 6, 32'h1234_5678);      // 16 sets x 4 ways, same capacity
        t_trace(7, 0, 10, 6, 32'h1234_5678);      // 128 sets direct-mapped
        t_reconfig_flush();
        t_counters();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule